// File: doc/BRIEF.md
# Dual-Channel Disk Host Task-File Registers

This block holds the byte-wide command-block and control registers of a legacy two-channel disk host interface. It sits on a simple I/O bus with a 16-bit port address, 8-bit write data, separate read and write strobes and an access-size code. Every access gets a response one cycle later, carrying the read data and an error flag. A static input gives each of the four drive positions a kind: hard disk, optical, or absent. The block decodes ports into channel and register, keeps per-channel and per-drive state, and runs the software-reset handshake driven by the reset bit of the control register.

Data transfers, command execution, interrupts and the device side are outside the block. Writes to the data and command ports are answered with the error flag and change nothing. The register that the host sees at each address depends on the drive chosen by the drive/head register and on that drive's kind.

Top module: `ata_taskfile_regs`

## Requirements
- R1: A port belongs to channel 0 when (port & 0xFFF8) == 0x1F0 or (port & 0xFFFE) == 0x3F6, and to channel 1 when (port & 0xFFF8) == 0x170 or (port & 0xFFFE) == 0x376. Any other port is answered with the error flag.
- R2: An access with io_size other than 0 (one byte), or with both strobes raised, is answered with the error flag and changes no register.
- R3: After power-on reset, every channel reads error 0x01, drive/head 0x00 and status 0x00. Every drive holds sector count 0x01, sector number 0x01 and cylinder 0x0000.
- R4: Sector count (+2), sector number (+3), cylinder low (+4) and cylinder high (+5) are stored per drive, and bit 4 of drive/head selects the drive. A sector-number write leaves cylinder low unchanged.
- R5: A drive/head write (+6) stores the value ORed with 0xA0. If the newly selected drive is absent, error bit 2 (abort) and status bit 0 (error) are set.
- R6: A control write (0x3F6/0x376) whose bit 2 goes from 0 to 1 sets status to 0x90 and error to 0x01. A write that leaves bit 2 unchanged starts nothing.
- R7: A control write whose bit 2 goes from 1 to 0 clears status bit 7 (busy), sets status bit 6 (ready) and zeroes drive/head bits 3:0. Both drives reload sector count 0x01 and sector number 0x01, with cylinder 0xEB14 for an optical drive and 0x0000 otherwise.
- R8: A read of 0x3F7/0x377 returns 0xFF without error, whatever drive is selected. A write there is answered with the error flag.
- R9: While the selected drive is absent, a read of drive/head returns 0xA0 and a read of any other register returns 0x00.
- R10: A read at +1 returns the error register. Reads at +7 and at the control port both return the status register.
- R11: Writes to the data port (+0) and to the command port (+7), and reads of the data port, are answered with the error flag and change no register.
- R12: resp_valid is high exactly in the cycle after a cycle with io_rd or io_wr high, and the response data and flag belong to that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 four bytes |
| drive_kind | input | 8 | Two bits per drive position, index 2*channel+drive: 00 disk, 01 optical, 1x absent |
| resp_valid | output | 1 | Response strobe |
| resp_rdata | output | 8 | Read data, 0 for writes and errors |
| resp_err | output | 1 | Access rejected |

## Verification
The bench builds the block with its default port bases. It ties drive_kind to 0x24: channel 0 holds a disk and an optical drive, and channel 1 holds an absent drive and a disk. This single configuration reaches every kind-dependent path. The optical cylinder signature and the disk's zero cylinder both appear in one reset completion. The abort on selecting an absent drive and the fixed absent read values appear on the other channel, and that channel also has a present drive, through which the abort bits can be read back.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [3:0] {
        RS_DATA, RS_ERRFEAT, RS_SCNT, RS_SNUM, RS_CYLLO, RS_CYLHI,
        RS_DH, RS_CMDSTAT, RS_CTRL, RS_ADDR, RS_NONE
    } reg_sel_e;

    localparam int ST_BUSY  = 7;
    localparam int ST_READY = 6;
    localparam int ST_ERR   = 0;
    localparam int ER_ABORT = 2;
    localparam int CT_SRST  = 2;
    localparam int DH_DRV   = 4;

    localparam logic [7:0]  STATUS_IN_RESET = 8'h90;
    localparam logic [7:0]  ERROR_CLEAN     = 8'h01;
    localparam logic [7:0]  DH_FIXED_BITS   = 8'hA0;
    localparam logic [15:0] OPTICAL_SIG     = 16'hEB14;

    typedef struct packed {
        logic [7:0]  scnt;
        logic [7:0]  snum;
        logic [15:0] cyl;
    } drive_regs_t;

    localparam drive_regs_t DRIVE_INIT = '{scnt: 8'h01, snum: 8'h01, cyl: 16'h0000};

    function automatic logic kind_absent(input logic [1:0] k);
        return k[1];
    endfunction

    function automatic logic kind_optical(input logic [1:0] k);
        return k == 2'b01;
    endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter logic [15:0] CH0_CMD_BASE = 16'h01F0,
    parameter logic [15:0] CH0_CTL_BASE = 16'h03F6,
    parameter logic [15:0] CH1_CMD_BASE = 16'h0170,
    parameter logic [15:0] CH1_CTL_BASE = 16'h0376
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              ch_idx,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] CMD_MASK = ~ADDR_W'(7);
    localparam logic [ADDR_W-1:0] CTL_MASK = ~ADDR_W'(1);

    function automatic reg_sel_e cmd_sel(input logic [2:0] off);
        case (off)
            3'd0:    return RS_DATA;
            3'd1:    return RS_ERRFEAT;
            3'd2:    return RS_SCNT;
            3'd3:    return RS_SNUM;
            3'd4:    return RS_CYLLO;
            3'd5:    return RS_CYLHI;
            3'd6:    return RS_DH;
            default: return RS_CMDSTAT;
        endcase
    endfunction

    always_comb begin
        hit    = 1'b1;
        ch_idx = 1'b0;
        sel    = RS_NONE;
        if ((addr & CMD_MASK) == ADDR_W'(CH0_CMD_BASE)) begin
            sel = cmd_sel(addr[2:0]);
        end else if ((addr & CTL_MASK) == ADDR_W'(CH0_CTL_BASE)) begin
            sel = addr[0] ? RS_ADDR : RS_CTRL;
        end else if ((addr & CMD_MASK) == ADDR_W'(CH1_CMD_BASE)) begin
            ch_idx = 1'b1;
            sel    = cmd_sel(addr[2:0]);
        end else if ((addr & CTL_MASK) == ADDR_W'(CH1_CTL_BASE)) begin
            ch_idx = 1'b1;
            sel    = addr[0] ? RS_ADDR : RS_CTRL;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/ata_tf_channel.sv
module ata_tf_channel
    import ata_tf_pkg::*;
#(
    parameter int DRIVES = 2,
    localparam int KIND_W = 2 * DRIVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [7:0]        wdata,
    input  logic [KIND_W-1:0] kind,
    output logic [7:0]        rdata
);
    typedef struct packed {
        logic [7:0]                err;
        logic [7:0]                status;
        logic [7:0]                dh;
        logic                      srst;
        drive_regs_t [DRIVES-1:0]  drv;
    } chan_state_t;

    chan_state_t q, d;

    logic       cur_drv;
    logic       cur_absent;
    logic [1:0] new_kind;
    logic [1:0] drv_kind [DRIVES];

    for (genvar i = 0; i < DRIVES; i++) begin : g_kind
        assign drv_kind[i] = kind[2*i +: 2];
    end

    assign cur_drv    = q.dh[DH_DRV];
    assign cur_absent = kind_absent(drv_kind[cur_drv]);
    assign new_kind   = drv_kind[wdata[DH_DRV]];

    // next-state
    always_comb begin
        d = q;
        if (wr_en) begin
            case (sel)
                RS_SCNT:  d.drv[cur_drv].scnt     = wdata;
                RS_SNUM:  d.drv[cur_drv].snum     = wdata;
                RS_CYLLO: d.drv[cur_drv].cyl[7:0]  = wdata;
                RS_CYLHI: d.drv[cur_drv].cyl[15:8] = wdata;
                RS_DH: begin
                    d.dh = wdata | DH_FIXED_BITS;
                    if (kind_absent(new_kind)) begin
                        d.err[ER_ABORT]  = 1'b1;
                        d.status[ST_ERR] = 1'b1;
                    end
                end
                RS_CTRL: begin
                    if (!q.srst && wdata[CT_SRST]) begin
                        d.status = STATUS_IN_RESET;
                        d.err    = ERROR_CLEAN;
                    end else if (q.srst && !wdata[CT_SRST]) begin
                        d.status[ST_BUSY]  = 1'b0;
                        d.status[ST_READY] = 1'b1;
                        d.dh[3:0]          = 4'h0;
                        for (int i = 0; i < DRIVES; i++) begin
                            d.drv[i] = DRIVE_INIT;
                            if (kind_optical(drv_kind[i])) begin
                                d.drv[i].cyl = OPTICAL_SIG;
                            end
                        end
                    end
                    d.srst = wdata[CT_SRST];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.err    <= ERROR_CLEAN;
            q.status <= 8'h00;
            q.dh     <= 8'h00;
            q.srst   <= 1'b0;
            for (int i = 0; i < DRIVES; i++) begin
                q.drv[i] <= DRIVE_INIT;
            end
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        rdata = 8'h00;
        if (sel == RS_ADDR) begin
            rdata = 8'hFF;
        end else if (cur_absent) begin
            rdata = (sel == RS_DH) ? DH_FIXED_BITS : 8'h00;
        end else begin
            case (sel)
                RS_ERRFEAT:          rdata = q.err;
                RS_SCNT:             rdata = q.drv[cur_drv].scnt;
                RS_SNUM:             rdata = q.drv[cur_drv].snum;
                RS_CYLLO:            rdata = q.drv[cur_drv].cyl[7:0];
                RS_CYLHI:            rdata = q.drv[cur_drv].cyl[15:8];
                RS_DH:               rdata = q.dh;
                RS_CMDSTAT, RS_CTRL: rdata = q.status;
                default:             rdata = 8'h00;
            endcase
        end
    end

    p_dh_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_DH) |=> (q.dh[7] && q.dh[5]))
        else $error("drive/head fixed bits missing");

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_DH && kind_absent(new_kind)) |=> (q.err[ER_ABORT] && q.status[ST_ERR]))
        else $error("absent select did not abort");

    p_reset_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_CTRL && !q.srst && wdata[CT_SRST])
        |=> (q.status == STATUS_IN_RESET && q.err == ERROR_CLEAN))
        else $error("reset start values wrong");

    p_reset_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_CTRL && q.srst && !wdata[CT_SRST])
        |=> (!q.status[ST_BUSY] && q.status[ST_READY] && q.dh[3:0] == 4'h0))
        else $error("reset completion wrong");

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q))
        else $error("state moved without a write");
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter logic [15:0] CH0_CMD_BASE = 16'h01F0,
    parameter logic [15:0] CH0_CTL_BASE = 16'h03F6,
    parameter logic [15:0] CH1_CMD_BASE = 16'h0170,
    parameter logic [15:0] CH1_CTL_BASE = 16'h0376
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [1:0]        io_size,
    input  logic [7:0]        drive_kind,
    output logic              resp_valid,
    output logic [7:0]        resp_rdata,
    output logic              resp_err
);
    localparam int NUM_CH    = 2;
    localparam int DRV_PER_CH = 2;
    localparam int KIND_W    = 2 * DRV_PER_CH;

    typedef struct packed {
        logic       valid;
        logic       err;
        logic [7:0] rdata;
    } resp_t;

    resp_t      resp_q, resp_d;
    logic       hit, ch_idx;
    reg_sel_e   sel;
    logic       bad;
    logic [7:0] ch_rdata [NUM_CH];
    logic       ch_wr    [NUM_CH];

    ata_tf_decode #(
        .ADDR_W(ADDR_W), .CH0_CMD_BASE(CH0_CMD_BASE), .CH0_CTL_BASE(CH0_CTL_BASE),
        .CH1_CMD_BASE(CH1_CMD_BASE), .CH1_CTL_BASE(CH1_CTL_BASE)
    ) u_dec (
        .addr(io_addr), .hit(hit), .ch_idx(ch_idx), .sel(sel)
    );

    always_comb begin
        bad = !hit || (io_size != 2'd0) || (io_rd && io_wr) || (sel == RS_DATA)
           || (io_wr && (sel == RS_CMDSTAT || sel == RS_ADDR));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_wr[c] = io_wr && !bad && (ch_idx == 1'(c));
        ata_tf_channel #(.DRIVES(DRV_PER_CH)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_en(ch_wr[c]), .sel(sel),
            .wdata(io_wdata), .kind(drive_kind[c*KIND_W +: KIND_W]),
            .rdata(ch_rdata[c])
        );
    end

    always_comb begin
        resp_d       = '0;
        resp_d.valid = io_rd || io_wr;
        if (io_rd || io_wr) begin
            resp_d.err = bad;
            if (io_rd && !bad) begin
                resp_d.rdata = ch_rdata[ch_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_err   = resp_q.err;
    assign resp_rdata = resp_q.rdata;

    p_resp_timing_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |=> resp_valid)
        else $error("missing response");

    p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd || io_wr) |=> !resp_valid)
        else $error("response without access");

    p_wide_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && io_size != 2'd0) |=> resp_err)
        else $error("wide access accepted");

    p_addr_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_size == 2'd0 &&
         (io_addr == ADDR_W'(CH0_CTL_BASE + 16'd1) || io_addr == ADDR_W'(CH1_CTL_BASE + 16'd1)))
        |=> (resp_rdata == 8'hFF && !resp_err))
        else $error("address register read wrong");
endmodule

// File: tb/ata_taskfile_regs_test.sv
`timescale 1ns/1ps
module ata_taskfile_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [1:0]  io_size = '0;
    logic [7:0]  drive_kind = 8'h24; // ch0: disk, optical; ch1: absent, disk
    logic        resp_valid;
    logic [7:0]  resp_rdata;
    logic        resp_err;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ata_taskfile_regs uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_size(io_size), .drive_kind(drive_kind),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic rd, input logic [15:0] a,
                          input logic [7:0] dat, input logic [1:0] sz,
                          output logic [7:0] rdat, output logic err);
        @(negedge clk);
        io_addr = a; io_wdata = dat; io_wr = wr; io_rd = rd; io_size = sz;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        rdat = resp_rdata;
        err  = resp_err;
    endtask

    task automatic wr8(input string req, input logic [15:0] a, input logic [7:0] dat, input logic exp_err);
        logic [7:0] r; logic e;
        access(1'b1, 1'b0, a, dat, 2'd0, r, e);
        chk(req, e, exp_err);
    endtask

    task automatic rd8(input string req, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] r; logic e;
        access(1'b0, 1'b1, a, 8'h00, 2'd0, r, e);
        chk(req, {e, r}, {1'b0, exp});
    endtask

    task automatic rd_err(input string req, input logic [15:0] a);
        logic [7:0] r; logic e;
        access(1'b0, 1'b1, a, 8'h00, 2'd0, r, e);
        chk(req, e, 1);
    endtask

    task automatic t_reset;
        rd8("R3 error", 16'h01F1, 8'h01);
        rd8("R3 scnt", 16'h01F2, 8'h01);
        rd8("R3 snum", 16'h01F3, 8'h01);
        rd8("R3 cyl lo", 16'h01F4, 8'h00);
        rd8("R3 cyl hi", 16'h01F5, 8'h00);
        rd8("R3 dh", 16'h01F6, 8'h00);
        rd8("R3 status", 16'h01F7, 8'h00);
        rd8("R9 absent err reg", 16'h0171, 8'h00);
        rd8("R9 absent dh", 16'h0176, 8'hA0);
    endtask

    task automatic t_drive_regs;
        wr8("R4 wr scnt", 16'h01F2, 8'h11, 0);
        wr8("R4 wr snum", 16'h01F3, 8'h22, 0);
        wr8("R4 wr cyl lo", 16'h01F4, 8'h33, 0);
        wr8("R4 wr cyl hi", 16'h01F5, 8'h44, 0);
        wr8("R5 select drive 1", 16'h01F6, 8'h10, 0);
        rd8("R5 dh or A0", 16'h01F6, 8'hB0);
        rd8("R4 drive1 scnt", 16'h01F2, 8'h01);
        wr8("R4 wr snum d1", 16'h01F3, 8'h55, 0);
        rd8("R4 snum leaves cyl lo", 16'h01F4, 8'h00);
        rd8("R4 snum d1", 16'h01F3, 8'h55);
        wr8("R5 select drive 0", 16'h01F6, 8'h00, 0);
        rd8("R5 dh A0", 16'h01F6, 8'hA0);
        rd8("R4 d0 scnt", 16'h01F2, 8'h11);
        rd8("R4 d0 snum", 16'h01F3, 8'h22);
        rd8("R4 d0 cyl lo", 16'h01F4, 8'h33);
        rd8("R4 d0 cyl hi", 16'h01F5, 8'h44);
        rd8("R5 no abort on present", 16'h01F1, 8'h01);
    endtask

    task automatic t_absent_select;
        wr8("R5 select absent", 16'h0176, 8'h00, 0);
        wr8("R5 select present", 16'h0176, 8'h10, 0);
        rd8("R5 abort bit", 16'h0171, 8'h05);
        rd8("R5 status err bit", 16'h0177, 8'h01);
        rd8("R10 ctrl port reads status", 16'h0376, 8'h01);
        rd8("R5 dh readback", 16'h0176, 8'hB0);
    endtask

    task automatic t_absent_reads;
        wr8("R9 select absent", 16'h0176, 8'h0F, 0);
        rd8("R9 dh fixed", 16'h0176, 8'hA0);
        rd8("R9 scnt zero", 16'h0172, 8'h00);
        rd8("R9 status zero", 16'h0177, 8'h00);
        rd8("R9 ctrl zero", 16'h0376, 8'h00);
        rd8("R8 addr reg absent", 16'h0377, 8'hFF);
        rd8("R8 addr reg ch0", 16'h03F7, 8'hFF);
    endtask

    task automatic t_soft_reset;
        wr8("R7 set head", 16'h01F6, 8'h0B, 0);
        rd8("R7 head set", 16'h01F6, 8'hAB);
        wr8("R6 reset rise", 16'h03F6, 8'h04, 0);
        rd8("R6 status", 16'h01F7, 8'h90);
        rd8("R6 error", 16'h01F1, 8'h01);
        rd8("R10 ctrl reads status", 16'h03F6, 8'h90);
        rd8("R6 drives not yet reset", 16'h01F2, 8'h11);
        wr8("R6 reset hold", 16'h03F6, 8'h04, 0);
        rd8("R6 no edge no change", 16'h01F7, 8'h90);
        wr8("R7 reset fall", 16'h03F6, 8'h00, 0);
        rd8("R7 status", 16'h01F7, 8'h50);
        rd8("R7 head zero", 16'h01F6, 8'hA0);
        rd8("R7 d0 scnt", 16'h01F2, 8'h01);
        rd8("R7 d0 snum", 16'h01F3, 8'h01);
        rd8("R7 d0 cyl lo", 16'h01F4, 8'h00);
        rd8("R7 d0 cyl hi", 16'h01F5, 8'h00);
        wr8("R7 select optical", 16'h01F6, 8'h10, 0);
        rd8("R7 optical snum", 16'h01F3, 8'h01);
        rd8("R7 optical cyl lo", 16'h01F4, 8'h14);
        rd8("R7 optical cyl hi", 16'h01F5, 8'hEB);
        wr8("R7 second fall no effect", 16'h03F6, 8'h00, 0);
        rd8("R7 status kept", 16'h01F7, 8'h50);
    endtask

    task automatic t_wide;
        logic [7:0] r; logic e;
        access(1'b1, 1'b0, 16'h01F2, 8'h77, 2'd1, r, e);
        chk("R2 wide write err", e, 1);
        access(1'b1, 1'b1, 16'h01F2, 8'h66, 2'd0, r, e);
        chk("R2 both strobes err", e, 1);
        rd8("R2 scnt unchanged", 16'h01F2, 8'h01);
        access(1'b0, 1'b1, 16'h01F2, 8'h00, 2'd2, r, e);
        chk("R2 wide read err", e, 1);
    endtask

    task automatic t_decode;
        rd_err("R1 port 1E0", 16'h01E0);
        rd_err("R1 port 3F5", 16'h03F5);
        rd_err("R1 port 3F8", 16'h03F8);
        rd8("R1 port 175 decoded", 16'h0175, 8'h00);
        rd8("R1 port 1F5 decoded", 16'h01F5, 8'hEB);
    endtask

    task automatic t_forbidden;
        wr8("R11 cmd write err", 16'h01F7, 8'hEC, 1);
        rd8("R11 status unchanged", 16'h01F7, 8'h50);
        wr8("R11 data write err", 16'h01F0, 8'h12, 1);
        rd_err("R11 data read err", 16'h01F0);
        wr8("R8 addr reg write err", 16'h0377, 8'h00, 1);
        wr8("R11 features write ok", 16'h01F1, 8'h03, 0);
        rd8("R10 +1 reads error reg", 16'h01F1, 8'h01);
    endtask

    task automatic t_timing;
        @(negedge clk);
        io_addr = 16'h01F2; io_rd = 1'b1; io_size = 2'd0;
        chk("R12 no valid before", resp_valid, 0);
        @(negedge clk);
        io_rd = 1'b0;
        chk("R12 valid next cycle", resp_valid, 1);
        chk("R12 data", resp_rdata, 8'h01);
        @(negedge clk);
        chk("R12 valid drops", resp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R12 watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 idle in reset", resp_valid, 0);
        rst_n = 1'b1;
        t_reset;
        t_drive_regs;
        t_absent_select;
        t_absent_reads;
        t_soft_reset;
        t_wide;
        t_decode;
        t_forbidden;
        t_timing;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule